// File: doc/BRIEF.md
# I/O Port Peripheral Access Decoder

This block sits between a CPU's I/O bus and two peripheral chips on a buffered data bus: a USB host controller and a network controller. It watches the CPU's I/O cycles and acts only on those whose low address byte equals a fixed port code (0xAB by default). The high address byte then picks a target. It can select the USB controller's address register or a wide data-port range. It can also select one of two local registers: a 4-bit page register and a configuration register.

The data-port range covers every high byte with bit 7 clear. A routing bit in the configuration register sends the whole range either to the USB controller's data register or to the network controller. On the network controller, the high address byte becomes part of the register address. The page register supplies the upper 4 address bits and I/O address bits 13:8 supply the lower 6. Address bit 0 can be inverted by a configuration bit.

The configuration register also drives the USB controller's active-low master/slave select. It also reports the level of a USB power sense input. Reads are passed straight through to the CPU within the same I/O cycle. Writes put the CPU data on the buffered bus for as long as the write strobe is low.

Top module: `io_periph_decoder`

## Requirements
- R1: An I/O cycle at address 0x80AB selects the USB controller (usb_cs_n low) with usb_a0 driven 0.
- R2: While configuration bit 4 is 0, an I/O cycle with address bit 15 clear and low byte 0xAB selects the USB controller with usb_a0 driven 1.
- R3: The page register at 0x81AB loads data bits 3:0 on a clock edge during a write cycle. It reads back in bits 3:0 with bits 7:4 zero, and it is unchanged by any other cycle.
- R4: While configuration bit 4 is 1, the same range selects the network controller instead (net_cs_n low). net_addr is then {page, addr[13:9], addr[8] XOR configuration bit 3}.
- R5: The configuration register at 0x82AB holds bits 6, 4 and 3, which are written on a clock edge during a write cycle. A read returns those bits, returns bit 7 as the live usb_pwr level, and returns all other bits as 0.
- R6: usb_ms_n is the inverse of configuration bit 6, and it is 1 whenever rst_n is low.
- R7: During a read cycle that selects a peripheral, bus_rd_n is low and cpu_rd_data equals bus_rdata, with cpu_rd_oe high in the same cycle.
- R8: During a write cycle that selects a peripheral, bus_wr_n is low, bus_wdata_oe is high and bus_wdata equals cpu_wr_data.
- R9: At most one chip select is low at a time. None is low when iorq_n is high, when neither strobe is low, when the low byte differs from 0xAB, or when the high byte is 0x83 or above.
- R10: cpu_rd_oe is high only during a read cycle that hits a peripheral or a local register. bus_wdata_oe, bus_rd_n and bus_wr_n are active only during a cycle that selects a peripheral.
- R11: After reset the page register and all writable configuration bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_iorq_n | input | 1 | CPU I/O request, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_wr_data | input | 8 | Data from the CPU |
| cpu_rd_data | output | 8 | Data to the CPU |
| cpu_rd_oe | output | 1 | Drive enable for the CPU data bus |
| bus_rdata | input | 8 | Data from the buffered peripheral bus |
| bus_wdata | output | 8 | Data to the buffered peripheral bus |
| bus_wdata_oe | output | 1 | Drive enable for the buffered bus |
| bus_rd_n | output | 1 | Peripheral read strobe |
| bus_wr_n | output | 1 | Peripheral write strobe |
| usb_cs_n | output | 1 | USB controller chip select |
| usb_a0 | output | 1 | USB controller register select (0 address, 1 data) |
| usb_ms_n | output | 1 | USB controller master/slave select, active low |
| usb_pwr | input | 1 | USB power sense |
| net_cs_n | output | 1 | Network controller chip select |
| net_addr | output | 10 | Network controller register address |

## Verification
The block's only state is the page register and three configuration bits. Any corruption of that state shows at the ports on the next decoded cycle that uses it. A wrong page shows in the upper four bits of net_addr. A wrong routing bit sends the data range to the wrong chip select. A wrong inversion bit flips net_addr bit 0, and a wrong master/slave bit shows on usb_ms_n at once. Readback through the CPU data bus exposes every stored bit in the cycle it is read. So a reference model compared on every clock catches a divergence within one decoded access.

// File: rtl/io_periph_decoder.sv
module io_periph_decoder #(
  parameter int          DW       = 8,
  parameter int          PAGE_W   = 4,
  parameter int          SUB_W    = 6,
  parameter logic [7:0]  PORT_LO  = 8'hAB,
  parameter logic [7:0]  UADDR_HI = 8'h80,
  parameter logic [7:0]  PAGE_HI  = 8'h81,
  parameter logic [7:0]  CFG_HI   = 8'h82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_iorq_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [DW-1:0]     cpu_wr_data,
  output logic [DW-1:0]     cpu_rd_data,
  output logic              cpu_rd_oe,
  input  logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_wdata_oe,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              usb_cs_n,
  output logic              usb_a0,
  output logic              usb_ms_n,
  input  logic              usb_pwr,
  output logic              net_cs_n,
  output logic [PAGE_W+SUB_W-1:0] net_addr
);
  localparam int NAW       = PAGE_W + SUB_W;
  localparam int B_A0INV   = 3;
  localparam int B_ROUTE   = 4;
  localparam int B_MS      = 6;
  localparam int B_PWR     = 7;

  logic [7:0]        hi;
  logic              cyc, rd, wr;
  logic              hit_uaddr, hit_range, hit_page, hit_cfg;
  logic              sel_usb, sel_net, periph;
  logic [PAGE_W-1:0] page_q;
  logic              ms_q, route_q, inv_q;
  logic [DW-1:0]     cfg_rd, page_rd;

  assign hi  = cpu_addr[15:8];
  assign rd  = !cpu_rd_n;
  assign wr  = !cpu_wr_n;
  assign cyc = !cpu_iorq_n && (rd || wr) && (cpu_addr[7:0] == PORT_LO);

  assign hit_uaddr = cyc && (hi == UADDR_HI);
  assign hit_range = cyc && !hi[7];
  assign hit_page  = cyc && (hi == PAGE_HI);
  assign hit_cfg   = cyc && (hi == CFG_HI);

  assign sel_usb = hit_uaddr || (hit_range && !route_q);
  assign sel_net = hit_range && route_q;
  assign periph  = sel_usb || sel_net;

  assign usb_cs_n = !sel_usb;
  assign usb_a0   = !hi[7];
  assign net_cs_n = !sel_net;
  assign net_addr = {page_q, cpu_addr[8+SUB_W-1:9], cpu_addr[8] ^ inv_q};
  assign usb_ms_n = !(rst_n && ms_q);

  assign bus_rd_n     = !(periph && rd);
  assign bus_wr_n     = !(periph && wr);
  assign bus_wdata    = cpu_wr_data;
  assign bus_wdata_oe = periph && wr;

  always_comb begin
    cfg_rd          = '0;
    cfg_rd[B_PWR]   = usb_pwr;
    cfg_rd[B_MS]    = ms_q;
    cfg_rd[B_ROUTE] = route_q;
    cfg_rd[B_A0INV] = inv_q;
    page_rd         = '0;
    page_rd[PAGE_W-1:0] = page_q;
  end

  assign cpu_rd_oe   = rd && (periph || hit_page || hit_cfg);
  assign cpu_rd_data = periph   ? bus_rdata :
                       hit_page ? page_rd   :
                       hit_cfg  ? cfg_rd    : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      ms_q    <= 1'b0;
      route_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      if (hit_page && wr) page_q <= cpu_wr_data[PAGE_W-1:0];
      if (hit_cfg && wr) begin
        ms_q    <= cpu_wr_data[B_MS];
        route_q <= cpu_wr_data[B_ROUTE];
        inv_q   <= cpu_wr_data[B_A0INV];
      end
    end
  end

  p_single_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!usb_cs_n, !net_cs_n}));

  p_idle_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_iorq_n |-> (usb_cs_n && net_cs_n));

  p_cpu_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_oe |-> (!cpu_iorq_n && !cpu_rd_n));

  p_bus_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_oe |-> (!cpu_wr_n && !bus_wr_n && (!usb_cs_n || !net_cs_n)));

  p_rd_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (cpu_rd_oe && (!usb_cs_n || !net_cs_n)));

  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_page && wr) |=> $stable(page_q));

  always_comb begin
    if (rst_n === 1'b0)
      p_ms_reset_r6: assert (usb_ms_n === 1'b1);
  end
endmodule

// File: tb/io_periph_decoder_tb.sv
`timescale 1ns/1ps
module io_periph_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_iorq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [7:0]  cpu_wr_data = '0, bus_rdata = '0;
  logic        usb_pwr = 1'b0;
  logic [7:0]  cpu_rd_data, bus_wdata;
  logic        cpu_rd_oe, bus_wdata_oe, bus_rd_n, bus_wr_n;
  logic        usb_cs_n, usb_a0, usb_ms_n, net_cs_n;
  logic [9:0]  net_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  io_periph_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_iorq_n(cpu_iorq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .cpu_rd_oe(cpu_rd_oe), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .usb_cs_n(usb_cs_n), .usb_a0(usb_a0), .usb_ms_n(usb_ms_n),
    .usb_pwr(usb_pwr), .net_cs_n(net_cs_n), .net_addr(net_addr));

  // reference state
  int m_page;
  bit m_ms, m_route, m_inv;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic bit is_cyc();
    return !cpu_iorq_n && (!cpu_rd_n || !cpu_wr_n) && cpu_addr[7:0] == 8'hAB;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_page <= 0; m_ms <= 0; m_route <= 0; m_inv <= 0;
    end else if (is_cyc() && !cpu_wr_n) begin
      if (cpu_addr[15:8] == 8'h81) m_page <= cpu_wr_data % 16;
      if (cpu_addr[15:8] == 8'h82) begin
        m_ms <= cpu_wr_data[6]; m_route <= cpu_wr_data[4]; m_inv <= cpu_wr_data[3];
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (!done) begin
      automatic bit c = is_cyc();
      automatic int h = cpu_addr[15:8];
      automatic bit e_usb = c && (h == 'h80 || (h < 'h80 && !m_route));
      automatic bit e_net = c && h < 'h80 && m_route;
      automatic bit e_per = e_usb || e_net;
      automatic bit e_rd = !cpu_rd_n, e_wr = !cpu_wr_n;
      automatic string t_sel = !c ? "R9" : (h == 'h80) ? "R1" :
                               (h < 'h80) ? (m_route ? "R4" : "R2") : "R9";
      automatic logic [7:0] e_data;
      chk(t_sel, {usb_cs_n, net_cs_n}, {!e_usb, !e_net});
      if (e_usb) chk(t_sel, usb_a0, h < 'h80);
      if (e_net) chk("R4", net_addr, m_page * 64 + ((h % 64) ^ m_inv));
      chk("R6", usb_ms_n, !(rst_n && m_ms));
      chk("R10", {bus_rd_n, bus_wr_n, bus_wdata_oe},
          {!(e_per && e_rd), !(e_per && e_wr), e_per && e_wr});
      if (e_per && e_wr) chk("R8", bus_wdata, cpu_wr_data);
      chk("R10", cpu_rd_oe, c && e_rd && (e_per || h == 'h81 || h == 'h82));
      if (c && e_rd) begin
        if (e_per) chk("R7", cpu_rd_data, bus_rdata);
        else if (h == 'h81) chk("R3", cpu_rd_data, m_page);
        else if (h == 'h82) begin
          e_data = {usb_pwr, m_ms, 1'b0, m_route, m_inv, 3'b000};
          chk("R5", cpu_rd_data, e_data);
        end
      end
    end
  end

  task automatic bus(input logic [15:0] a, input int kind, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_iorq_n = (kind == 0);
    cpu_rd_n = (kind != 1);
    cpu_wr_n = (kind != 2);
    cpu_wr_data = d;
    bus_rdata = $urandom;
  endtask

  task automatic idle();
    bus(16'h0000, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state at the pins and via readback
    chk("R11", {usb_cs_n, net_cs_n, usb_ms_n}, 3'b111);
    rst_n = 1'b1;
    bus(16'h81AB, 1, 0); #2 chk("R11", cpu_rd_data, 8'h00);
    bus(16'h82AB, 1, 0); #2 chk("R11", cpu_rd_data, 8'h00);
    // R1 / R2 directed
    bus(16'h80AB, 2, 8'h5A); #2 chk("R1", {usb_cs_n, usb_a0, bus_wdata}, {1'b0, 1'b0, 8'h5A});
    bus(16'h37AB, 1, 0); #2 chk("R2", {usb_cs_n, usb_a0, net_cs_n}, 3'b011);
    // R3 page
    bus(16'h81AB, 2, 8'hFB); bus(16'h81AB, 1, 0); #2 chk("R3", cpu_rd_data, 8'h0B);
    // R5 config with power sense
    usb_pwr = 1'b1;
    bus(16'h82AB, 2, 8'hFF); bus(16'h82AB, 1, 0); #2 chk("R5", cpu_rd_data, 8'hD8);
    chk("R6", usb_ms_n, 1'b0);
    // R4 network routing with inversion
    bus(16'h2AAB, 1, 0); #2 chk("R4", {net_cs_n, usb_cs_n, net_addr}, {2'b01, 10'h2EB});
    // R9 wrong low byte, high register, no strobe
    bus(16'h2AAC, 1, 0); #2 chk("R9", {usb_cs_n, net_cs_n, cpu_rd_oe}, 3'b110);
    bus(16'h83AB, 2, 8'h33); #2 chk("R9", {usb_cs_n, net_cs_n, bus_wr_n}, 3'b111);
    bus(16'h81AB, 1, 0); #2 chk("R3", cpu_rd_data, 8'h0B);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom % 16;
      automatic logic [15:0] a;
      if (r < 6) a = {1'b0, 7'($urandom), 8'hAB};
      else if (r < 8) a = 16'h80AB;
      else if (r < 10) a = 16'h81AB;
      else if (r < 12) a = 16'h82AB;
      else if (r < 14) a = {8'($urandom), 8'hAB};
      else a = 16'($urandom);
      if ($urandom % 8 == 0) usb_pwr = $urandom;
      bus(a, $urandom % 3, $urandom);
      if ($urandom % 500 == 0) begin
        // mid-run reset: R6 release level and R11 clear
        @(negedge clk); rst_n = 1'b0;
        #2 chk("R6", usb_ms_n, 1'b1);
        @(negedge clk); rst_n = 1'b1;
      end
    end
    idle(); idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    done = 1;
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule